// File: doc/BRIEF.md
# One-Time-Programmable Fuse Controller

This block connects a processor's register port to a small one-time-programmable bit array. In the array a bit can change from 0 to 1 and never back. Software drives the block through a handful of registers. It loads a command code, a row address and the data words, writes 1 to the start bit, and then polls the status register until the done flag appears. After that it writes 0 to the start bit, which lets the sequencer accept the next command. Nothing happens until bit 0 of the mode register has been set.

Writing to the array is locked after reset. Software unlocks it with four program-enable commands whose data words are 0xF, 0x4, 0x8 and 0xD, in that order, each one started and acknowledged separately. Once the fourth value is accepted, status bit 2 (program OK) rises. A program-disable command locks the array again. A program-row command ORs the data into the stored row. Its run time grows with the number of 1 bits written, so writing all ones takes the longest. With `WORDS` = 2 a row is 64 bits wide and uses two data words. With `WORDS` = 1 a row is a single 32-bit word.

The sequencer has four states: IDLE, READ, PROG and DONE. The transitions are:
- IDLE goes to READ when a read is started.
- IDLE goes to PROG when a program-row command is started while the array is unlocked.
- IDLE goes straight to DONE for every other started command, including a program-row command issued while the array is locked.
- READ goes to DONE and PROG goes to DONE when the latency counter reaches zero.
- DONE goes back to IDLE once the start bit reads 0.

Top module: `fuse_ctrl`

## Requirements
- R1: After reset, the mode, command, start, status, address, write-data and read-data registers all read as 0.
- R2: While mode bit 0 is 0, writing start bit 0 as 1 launches nothing, and status bit 1 stays 0.
- R3: The address register at 0x28 keeps only bits 15:0 of the written value. The command register at 0x4 keeps only bits 5:0.
- R4: Status bit 1 (done) rises when a command completes. It stays at 1 while start bit 0 is 1, and it clears one cycle after start is written as 0.
- R5: A read (code 0x0) raises done READ_LAT+1 cycles after the start write. It leaves the addressed row in the read-data register at 0x10.
- R6: Four program-enable commands (code 0x2) with write data 0xF, 0x4, 0x8 and 0xD, in that order, set status bit 2. Bit 2 stays 0 after only the first three.
- R7: A program-enable value that does not match the next expected value sends the sequence back to its first value. The mismatched value is discarded and is not re-checked as a first value.
- R8: A program-disable command (code 0x3) clears status bit 2.
- R9: A program-row command (code 0x8) issued while locked completes with done and leaves the row unchanged.
- R10: Programming ORs the write data into the stored row. Bits that are already set are never cleared.
- R11: An unlocked program-row command raises done 1 + PROG_BASE + PROG_PER_BIT × (number of 1 bits in the row data) cycles after the start write.
- R12: With WORDS = 2, the second word is written at 0x64 and read back at 0x5C. Both words are programmed and read as one row.
- R13: Any other command code completes with done. It changes neither the array nor the unlock state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe, single cycle |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from bus_addr |

## Verification
The assertions check on every cycle that:
- done holds while start stays high;
- a cleared mode bit keeps the sequencer idle;
- an array write only happens while the array is unlocked;
- no stored bit ever falls;
- program OK rises only on the final key value and drops after a disable.

Only the bench scenarios can show the exact read and program latencies, the order of the unlock values and the restart after a mismatch, the OR-merging of row contents, and the masking of register bits.

// File: rtl/fuse_pkg.sv
package fuse_pkg;

    localparam logic [7:0] OFS_MODE  = 8'h00;
    localparam logic [7:0] OFS_CMD   = 8'h04;
    localparam logic [7:0] OFS_START = 8'h08;
    localparam logic [7:0] OFS_STAT  = 8'h0C;
    localparam logic [7:0] OFS_RD0   = 8'h10;
    localparam logic [7:0] OFS_ADDR  = 8'h28;
    localparam logic [7:0] OFS_WD0   = 8'h2C;
    localparam logic [7:0] OFS_RD1   = 8'h5C;
    localparam logic [7:0] OFS_WD1   = 8'h64;

    localparam logic [5:0] CMD_READ   = 6'h00;
    localparam logic [5:0] CMD_UNLOCK = 6'h02;
    localparam logic [5:0] CMD_LOCK   = 6'h03;
    localparam logic [5:0] CMD_PROG   = 6'h08;

    typedef enum logic [1:0] {
        S_IDLE,
        S_READ,
        S_PROG,
        S_DONE
    } seq_state_e;

    function automatic logic [31:0] unlock_key(input logic [1:0] idx);
        case (idx)
            2'd0:    unlock_key = 32'h0000_000F;
            2'd1:    unlock_key = 32'h0000_0004;
            2'd2:    unlock_key = 32'h0000_0008;
            default: unlock_key = 32'h0000_000D;
        endcase
    endfunction

    function automatic logic [7:0] wr_word_ofs(input int w);
        wr_word_ofs = (w == 0) ? OFS_WD0 : OFS_WD1;
    endfunction

    function automatic logic [7:0] rd_word_ofs(input int w);
        rd_word_ofs = (w == 0) ? OFS_RD0 : OFS_RD1;
    endfunction

endpackage

// File: rtl/fuse_regs.sv
module fuse_regs
    import fuse_pkg::*;
#(
    parameter int WORDS  = 2,
    parameter int ADDR_W = 16,
    parameter int CMD_W  = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic [7:0]            bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    output logic                  mode_en,
    output logic [CMD_W-1:0]      cmd,
    output logic                  start,
    output logic [ADDR_W-1:0]     row_addr,
    output logic [WORDS*32-1:0]   wdata,
    input  logic [WORDS*32-1:0]   rdata_row,
    input  logic                  st_done,
    input  logic                  st_prog_ok
);

    localparam int ROW_W = WORDS * 32;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_en  <= 1'b0;
            cmd      <= '0;
            start    <= 1'b0;
            row_addr <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                OFS_MODE:  mode_en  <= bus_wdata[0];
                OFS_CMD:   cmd      <= bus_wdata[CMD_W-1:0];
                OFS_START: start    <= bus_wdata[0];
                OFS_ADDR:  row_addr <= bus_wdata[ADDR_W-1:0];
                default:   ;
            endcase
        end
    end

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        logic [31:0] word_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                word_q <= '0;
            else if (bus_wr && bus_addr == wr_word_ofs(w))
                word_q <= bus_wdata;
        end
        assign wdata[w*32 +: 32] = word_q;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_MODE:  bus_rdata = {31'b0, mode_en};
            OFS_CMD:   bus_rdata = {{(32-CMD_W){1'b0}}, cmd};
            OFS_START: bus_rdata = {31'b0, start};
            OFS_STAT:  bus_rdata = {29'b0, st_prog_ok, st_done, 1'b0};
            OFS_ADDR:  bus_rdata = {{(32-ADDR_W){1'b0}}, row_addr};
            default:   ;
        endcase
        for (int w = 0; w < WORDS; w++) begin
            if (bus_addr == wr_word_ofs(w)) bus_rdata = wdata[w*32 +: 32];
            if (bus_addr == rd_word_ofs(w)) bus_rdata = rdata_row[w*32 +: 32];
        end
    end

    AST_ADDR_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_ADDR) |=> (row_addr == $past(bus_wdata[ADDR_W-1:0]))) // R3
        else $error("address register not masked");

    initial begin
        assert (ROW_W == 32 || ROW_W == 64) else $error("WORDS must be 1 or 2");
    end

endmodule

// File: rtl/fuse_unlock.sv
module fuse_unlock
    import fuse_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        step_en,
    input  logic [31:0] step_val,
    input  logic        clear,
    output logic        unlocked
);

    logic [1:0] step_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q   <= '0;
            unlocked <= 1'b0;
        end else if (clear) begin
            step_q   <= '0;
            unlocked <= 1'b0;
        end else if (step_en) begin
            if (step_val == unlock_key(step_q)) begin
                if (step_q == 2'd3) begin
                    unlocked <= 1'b1;
                    step_q   <= '0;
                end else begin
                    step_q <= step_q + 2'd1;
                end
            end else begin
                step_q <= '0;
            end
        end
    end

    AST_UNLOCK_ON_LAST_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> ($past(step_en) && $past(step_val) == 32'h0000_000D)) // R6
        else $error("unlock rose without final key");

    AST_LOCK_ON_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !unlocked) // R8
        else $error("unlock survived disable");

endmodule

// File: rtl/fuse_seq.sv
module fuse_seq
    import fuse_pkg::*;
#(
    parameter int WORDS        = 2,
    parameter int ROWS         = 16,
    parameter int CMD_W        = 6,
    parameter int READ_LAT     = 4,
    parameter int PROG_BASE    = 2,
    parameter int PROG_PER_BIT = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     mode_en,
    input  logic [CMD_W-1:0]         cmd,
    input  logic                     start,
    input  logic [$clog2(ROWS)-1:0]  row_idx,
    input  logic [WORDS*32-1:0]      wdata,
    input  logic                     unlocked,
    output logic                     step_en,
    output logic                     clear,
    output logic [WORDS*32-1:0]      rdata_row,
    output logic                     done
);

    localparam int ROW_W   = WORDS * 32;
    localparam int IDX_W   = $clog2(ROWS);
    localparam int MAX_LAT = PROG_BASE + PROG_PER_BIT * ROW_W + READ_LAT;
    localparam int CNT_W   = $clog2(MAX_LAT + 1);

    seq_state_e          state, state_nx;
    logic [CNT_W-1:0]    cnt_q;
    logic [IDX_W-1:0]    idx_q;
    logic [ROW_W-1:0]    data_q;
    logic [ROW_W-1:0]    arr_q [ROWS];
    logic                launch;
    logic                arr_we;

    function automatic int ones(input logic [ROW_W-1:0] v);
        int n = 0;
        for (int i = 0; i < ROW_W; i++) n += int'(v[i]);
        return n;
    endfunction

    assign launch = (state == S_IDLE) && start && mode_en;
    assign arr_we = (state == S_PROG) && (cnt_q == '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (launch) begin
                case (cmd)
                    CMD_READ: state_nx = S_READ;
                    CMD_PROG: state_nx = unlocked ? S_PROG : S_DONE;
                    default:  state_nx = S_DONE;
                endcase
            end
            S_READ: if (cnt_q == '0) state_nx = S_DONE;
            S_PROG: if (cnt_q == '0) state_nx = S_DONE;
            S_DONE: if (!start) state_nx = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        done    = (state == S_DONE);
        step_en = launch && (cmd == CMD_UNLOCK);
        clear   = launch && (cmd == CMD_LOCK);
    end

    // datapath: latency counter, snapshot, array, read register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            idx_q     <= '0;
            data_q    <= '0;
            rdata_row <= '0;
            for (int r = 0; r < ROWS; r++) arr_q[r] <= '0;
        end else begin
            if (launch) begin
                idx_q  <= row_idx;
                data_q <= wdata;
                if (cmd == CMD_READ)
                    cnt_q <= CNT_W'(READ_LAT - 1);
                else
                    cnt_q <= CNT_W'(PROG_BASE + PROG_PER_BIT * ones(wdata) - 1);
            end else if ((state == S_READ || state == S_PROG) && cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
            if (state == S_READ && cnt_q == '0)
                rdata_row <= arr_q[idx_q];
            if (arr_we)
                arr_q[idx_q] <= arr_q[idx_q] | data_q;
        end
    end

    AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> done) // R4
        else $error("done dropped while start high");

    AST_MODE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && !mode_en) |=> (state == S_IDLE)) // R2
        else $error("sequencer left idle with mode off");

    AST_WRITE_NEEDS_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> unlocked) // R9
        else $error("array written while locked");

    for (genvar r = 0; r < ROWS; r++) begin : g_keep
        AST_BITS_NEVER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(arr_q[r]) & ~arr_q[r]) == '0) // R10
            else $error("fuse bit cleared");
    end

    initial begin
        assert (READ_LAT >= 1 && PROG_BASE >= 1 && ROWS >= 2)
            else $error("bad latency or depth parameter");
    end

endmodule

// File: rtl/fuse_ctrl.sv
module fuse_ctrl
    import fuse_pkg::*;
#(
    parameter int WORDS        = 2,
    parameter int ROWS         = 16,
    parameter int ADDR_W       = 16,
    parameter int READ_LAT     = 4,
    parameter int PROG_BASE    = 2,
    parameter int PROG_PER_BIT = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata
);

    localparam int CMD_W = 6;
    localparam int ROW_W = WORDS * 32;
    localparam int IDX_W = $clog2(ROWS);

    logic               mode_en, start, done, unlocked, step_en, clear;
    logic [CMD_W-1:0]   cmd;
    logic [ADDR_W-1:0]  row_addr;
    logic [ROW_W-1:0]   wdata, rdata_row;

    fuse_regs #(.WORDS(WORDS), .ADDR_W(ADDR_W), .CMD_W(CMD_W)) u_regs (
        .clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
        .mode_en, .cmd, .start, .row_addr, .wdata, .rdata_row,
        .st_done(done), .st_prog_ok(unlocked)
    );

    fuse_unlock u_unlock (
        .clk, .rst_n, .step_en, .step_val(wdata[31:0]), .clear, .unlocked
    );

    fuse_seq #(
        .WORDS(WORDS), .ROWS(ROWS), .CMD_W(CMD_W), .READ_LAT(READ_LAT),
        .PROG_BASE(PROG_BASE), .PROG_PER_BIT(PROG_PER_BIT)
    ) u_seq (
        .clk, .rst_n, .mode_en, .cmd, .start,
        .row_idx(row_addr[IDX_W-1:0]), .wdata, .unlocked,
        .step_en, .clear, .rdata_row, .done
    );

endmodule

// File: tb/sim_fuse_ctrl.sv
module sim_fuse_ctrl;
    import fuse_pkg::*;

    localparam int READ_LAT = 4;
    localparam int PBASE    = 2;
    localparam int PBIT     = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    fuse_ctrl u0 (.clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata);

    // register table: write flag, offset, data, expected read value
    localparam int NV = 8;
    localparam logic        V_WR  [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
    localparam logic [7:0]  V_ADR [NV] = '{8'h0C, 8'h10, 8'h28, 8'h28, 8'h04, 8'h04, 8'h28, 8'h28};
    localparam logic [31:0] V_DAT [NV] = '{32'h0, 32'h0, 32'h0001_ABCD, 32'h0, 32'h0000_00FF, 32'h0, 32'hFFFF_1234, 32'h0};
    localparam logic [31:0] V_EXP [NV] = '{32'h0, 32'h0, 32'h0, 32'h0000_ABCD, 32'h0, 32'h0000_003F, 32'h0, 32'h0000_1234};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic run_cmd(input logic [5:0] c, output int cyc);
        logic [31:0] s;
        wr(OFS_CMD, {26'b0, c});
        wr(OFS_START, 32'h1);
        cyc = 0;
        rd(OFS_STAT, s);
        while (!s[1] && cyc < 1000) begin
            @(negedge clk);
            cyc++;
            rd(OFS_STAT, s);
        end
        wr(OFS_START, 32'h0);
        @(negedge clk);
    endtask

    task automatic unlock_val(input logic [31:0] v);
        int c;
        wr(OFS_WD0, v);
        run_cmd(CMD_UNLOCK, c);
    endtask

    task automatic prog_row(input logic [15:0] row, input logic [31:0] d0,
                            input logic [31:0] d1, output int cyc);
        wr(OFS_ADDR, {16'b0, row});
        wr(OFS_WD0, d0);
        wr(OFS_WD1, d1);
        run_cmd(CMD_PROG, cyc);
    endtask

    task automatic read_row(input logic [15:0] row, output logic [31:0] r0,
                            output logic [31:0] r1, output int cyc);
        wr(OFS_ADDR, {16'b0, row});
        run_cmd(CMD_READ, cyc);
        rd(OFS_RD0, r0);
        rd(OFS_RD1, r1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v, r0, r1;
        int c, c1, c64, c5;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        rd(OFS_MODE, v);  chk("R1 mode", v, 32'h0);
        rd(OFS_START, v); chk("R1 start", v, 32'h0);
        rd(OFS_WD1, v);   chk("R1 wdata1", v, 32'h0);

        // table walk: R1 reset state and R3 masking
        for (int i = 0; i < NV; i++) begin
            if (V_WR[i]) wr(V_ADR[i], V_DAT[i]);
            else begin
                rd(V_ADR[i], v);
                chk($sformatf("R1/R3 vec%0d", i), v, V_EXP[i]);
            end
        end

        // R2 mode gate
        wr(OFS_CMD, 32'h0);
        wr(OFS_START, 32'h1);
        repeat (10) @(negedge clk);
        rd(OFS_STAT, v); chk("R2 no done with mode off", v, 32'h0);
        wr(OFS_START, 32'h0);
        wr(OFS_MODE, 32'h1);

        // R4 done holds until start cleared
        wr(OFS_ADDR, 32'h0);
        wr(OFS_START, 32'h1);
        repeat (READ_LAT + 5) @(negedge clk);
        rd(OFS_STAT, v); chk("R4 done held", v & 32'h2, 32'h2);
        wr(OFS_START, 32'h0);
        rd(OFS_STAT, v); chk("R4 done one cycle after clear", v & 32'h2, 32'h2);
        @(negedge clk);
        rd(OFS_STAT, v); chk("R4 done cleared", v & 32'h2, 32'h0);

        // R9 program while locked
        prog_row(16'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, c);
        chk("R9 locked program completes", c, 1);
        read_row(16'd3, r0, r1, c);
        chk("R9 row untouched", r0 | r1, 32'h0);
        chk("R5 read latency", c, 1 + READ_LAT);

        // R7 wrong value then out of order
        unlock_val(32'hF); unlock_val(32'h4); unlock_val(32'h5); unlock_val(32'h8); unlock_val(32'hD);
        rd(OFS_STAT, v); chk("R7 wrong value restarts", v, 32'h0);
        unlock_val(32'h4); unlock_val(32'hF); unlock_val(32'h8); unlock_val(32'hD);
        rd(OFS_STAT, v); chk("R7 out of order stays locked", v, 32'h0);

        // R6 correct sequence
        unlock_val(32'hF); unlock_val(32'h4); unlock_val(32'h8);
        rd(OFS_STAT, v); chk("R6 three values not enough", v, 32'h0);
        unlock_val(32'hD);
        rd(OFS_STAT, v); chk("R6 program ok set", v, 32'h4);

        // R11 / R12 / R10 programming
        prog_row(16'd3, 32'h0000_00F0, 32'h0000_0001, c5);
        chk("R11 latency five ones", c5, 1 + PBASE + PBIT * 5);
        read_row(16'd3, r0, r1, c);
        chk("R12 word0", r0, 32'h0000_00F0);
        chk("R12 word1", r1, 32'h0000_0001);
        prog_row(16'd3, 32'h0000_000F, 32'h0, c);
        prog_row(16'd3, 32'h0, 32'h0, c);
        read_row(16'd3, r0, r1, c);
        chk("R10 OR merge word0", r0, 32'h0000_00FF);
        chk("R10 bits kept word1", r1, 32'h0000_0001);
        prog_row(16'd5, 32'hFFFF_FFFF, 32'hFFFF_FFFF, c64);
        prog_row(16'd6, 32'h0000_0001, 32'h0, c1);
        chk("R11 all ones latency", c64, 1 + PBASE + PBIT * 64);
        chk("R11 single bit latency", c1, 1 + PBASE + PBIT);
        read_row(16'd5, r0, r1, c);
        chk("R12 full row", r0 & r1, 32'hFFFF_FFFF);

        // R13 unknown code
        wr(OFS_ADDR, 32'h3);
        wr(OFS_WD0, 32'h0);
        run_cmd(6'h3F, c);
        chk("R13 unknown completes", c, 1);
        rd(OFS_STAT, v); chk("R13 unlock unchanged", v, 32'h4);
        read_row(16'd3, r0, r1, c);
        chk("R13 row unchanged", r0, 32'h0000_00FF);

        // R8 disable then program has no effect
        run_cmd(CMD_LOCK, c);
        rd(OFS_STAT, v); chk("R8 program ok cleared", v, 32'h0);
        prog_row(16'd7, 32'h1234_5678, 32'h1, c);
        read_row(16'd7, r0, r1, c);
        chk("R9 relocked no write", r0 | r1, 32'h0);

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

endmodule